// File: doc/BRIEF.md
# Mouse Motion Packet Encoder

This block converts one sample of pointer motion (signed X and Y deltas plus three button states) into a five-byte packet and loads the bytes, oldest first, into an on-chip byte FIFO from which a downstream serializer pops them. The first byte holds a fixed marker pattern with the buttons encoded active-low. The second byte carries the X motion and the third carries the inverted Y motion, both clamped to a symmetric range. The last two bytes are always zero.

A sample is offered by pulsing `evt_valid` with the deltas and buttons on the same cycle. The encoder captures it and spends the next five cycles writing one byte per cycle. During that time `busy` is high and further samples are ignored, so the producer waits for `busy` to fall before offering the next one. If the FIFO is full, the bytes that arrive are discarded. A pop from an empty FIFO yields zero and has no other effect.

Top module: `mouse_pkt_enc`

## Requirements
- R1: Byte 0 of each packet is 0x87 with bit 2 cleared when the left button is pressed (`evt_btn[2]`=1), bit 1 cleared for the middle button (`evt_btn[1]`), and bit 0 cleared for the right button (`evt_btn[0]`).
- R2: Byte 1 is `evt_dx` read as two's complement and limited to the range -127..+127, then sent as an 8-bit two's-complement value (-128 and below give 0x81, +128 and above give 0x7F).
- R3: Byte 2 is the arithmetic negation of `evt_dy`, computed without overflow and then limited to -127..+127 (an input of -512 gives 0x7F).
- R4: Bytes 3 and 4 are always 0x00.
- R5: The five bytes of a packet leave the FIFO in the order byte 0, 1, 2, 3, 4, and packets leave in the order they were accepted.
- R6: A sample presented while `busy` is low is accepted on that clock edge. `busy` is then high for exactly five cycles, one byte is written per cycle, and `busy` is low again once the fifth byte is stored.
- R7: A sample presented while `busy` is high is ignored and does not alter the packet in progress.
- R8: The FIFO holds up to 256 bytes. A byte written while it is full is dropped, and `fifo_count` never exceeds 256.
- R9: A pop (`rd_en`) while the FIFO is empty leaves `fifo_count` at 0, and `rd_data` reads 0x00 whenever the FIFO is empty.
- R10: After reset `busy` is 0, `fifo_count` is 0, `fifo_empty` is 1 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Motion sample strobe |
| evt_dx | input | 10 | Signed X delta |
| evt_dy | input | 10 | Signed Y delta |
| evt_btn | input | 3 | Buttons: [2] left, [1] middle, [0] right, 1 = pressed |
| busy | output | 1 | Packet being written; samples ignored |
| rd_en | input | 1 | Pop one byte from the FIFO |
| rd_data | output | 8 | Byte at the FIFO head (0x00 when empty) |
| fifo_count | output | 9 | Number of bytes held |
| fifo_empty | output | 1 | FIFO holds no bytes |

## Verification
The hardest case to reach from the ports is a FIFO that fills up in the middle of a packet, so that the first byte is stored and the rest are discarded. The stimulus reaches it by sending 52 packets without popping. That stores 255 bytes from the first 51 packets and only the marker byte of the 52nd. The whole FIFO is then drained and compared byte by byte, which also shows that the wrap of the pointers keeps the order. Samples offered while `busy` is high, and pops on an empty FIFO, are checked through the contents and count observed afterwards.

// File: rtl/mpk_pkg.sv
package mpk_pkg;
   localparam int unsigned PKT_LEN   = 5;
   localparam int unsigned BYTE_W    = 8;
   localparam logic [7:0]  HDR_BASE  = 8'h87;
   localparam int unsigned BTN_W     = 3;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [PKT_LEN-1:0][BYTE_W-1:0] pkt_t;
endpackage

// File: rtl/mpk_axis_clamp.sv
module mpk_axis_clamp #(
   parameter int unsigned DW     = 10,
   parameter int unsigned LIM    = 127,
   parameter bit          INVERT = 1'b0
) (
   input  logic [DW-1:0] delta_i,
   output logic [7:0]    byte_o
);
   localparam int unsigned EW = DW + 1;
   localparam logic signed [EW-1:0] HI = EW'(LIM);
   localparam logic signed [EW-1:0] LO = -EW'(LIM);

   initial begin
      if (DW < 8)  $error("mpk_axis_clamp: DW must be at least 8");
      if (LIM > 127) $error("mpk_axis_clamp: LIM must fit a signed byte");
   end

   logic signed [EW-1:0] ext;
   logic signed [EW-1:0] sel;
   logic signed [EW-1:0] lim;

   assign ext = {delta_i[DW-1], delta_i};

   generate
      if (INVERT) begin : g_neg
         assign sel = -ext;
      end else begin : g_pass
         assign sel = ext;
      end
   endgenerate

   always_comb begin
      if (sel > HI)      lim = HI;
      else if (sel < LO) lim = LO;
      else               lim = sel;
   end

   assign byte_o = lim[7:0];

   // R2 / R3: the output byte never encodes -128
   always_comb begin
      p_clamp_range_r2: assert (byte_o != 8'h80);
   end
endmodule

// File: rtl/mpk_pkt_seq.sv
module mpk_pkt_seq
   import mpk_pkg::*;
#(
   parameter int unsigned LEN = PKT_LEN
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  evt_valid,
   input  pkt_t  pkt_i,
   output logic  busy,
   output logic  wr_en,
   output byte_t wr_data
);
   localparam int unsigned IW   = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [IW-1:0] LAST = IW'(LEN - 1);

   initial begin
      if (LEN != PKT_LEN) $error("mpk_pkt_seq: LEN must equal PKT_LEN");
   end

   pkt_t          hold;
   logic [IW-1:0] idx;
   logic          active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold   <= '0;
         idx    <= '0;
         active <= 1'b0;
      end else if (!active) begin
         if (evt_valid) begin
            hold   <= pkt_i;
            idx    <= '0;
            active <= 1'b1;
         end
      end else begin
         if (idx == LAST) begin
            active <= 1'b0;
            idx    <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign busy    = active;
   assign wr_en   = active;
   assign wr_data = hold[idx];

   // run-length checker for the busy window
   logic [IW:0] run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + 1'b1;
      else           run <= '0;
   end

   p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run < (IW+1)'(LEN)));
   p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(run) == (IW+1)'(LEN - 1)));
   p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(evt_valid));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(hold));
endmodule

// File: rtl/mpk_byte_fifo.sv
module mpk_byte_fifo #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned W     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [W-1:0]             wr_data,
   input  logic                     rd_en,
   output logic [W-1:0]             rd_data,
   output logic [$clog2(DEPTH):0]   count,
   output logic                     empty
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;
   localparam logic [CW-1:0] FULLV = CW'(DEPTH);

   initial begin
      if (DEPTH < 2 || (1 << AW) != DEPTH)
         $error("mpk_byte_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_wr, do_rd, full;

   assign full  = (cnt == FULLV);
   assign empty = (cnt == '0);
   assign do_wr = wr_en && !full;
   assign do_rd = rd_en && !empty;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_wr) wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign rd_data = empty ? '0 : mem[rp];
   assign count   = cnt;

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULLV);
   p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en) |=> (count == FULLV));
   p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !wr_en) |=> empty);
   p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (rd_data == '0));
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
   import mpk_pkg::*;
#(
   parameter int unsigned DELTA_W = 10,
   parameter int unsigned CLAMP   = 127,
   parameter int unsigned DEPTH   = 256
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     evt_valid,
   input  logic [DELTA_W-1:0]       evt_dx,
   input  logic [DELTA_W-1:0]       evt_dy,
   input  logic [BTN_W-1:0]         evt_btn,
   output logic                     busy,
   input  logic                     rd_en,
   output logic [7:0]               rd_data,
   output logic [$clog2(DEPTH):0]   fifo_count,
   output logic                     fifo_empty
);
   localparam int unsigned N_AXIS = 2;

   logic [N_AXIS-1:0][DELTA_W-1:0] axis_in;
   logic [N_AXIS-1:0][7:0]         axis_byte;
   pkt_t  pkt;
   logic  wr_en;
   byte_t wr_data;

   assign axis_in[0] = evt_dx;
   assign axis_in[1] = evt_dy;

   generate
      for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
         mpk_axis_clamp #(
            .DW     (DELTA_W),
            .LIM    (CLAMP),
            .INVERT (a == 1)
         ) u_clamp (
            .delta_i (axis_in[a]),
            .byte_o  (axis_byte[a])
         );
      end
   endgenerate

   // active-low buttons in the marker byte; trailing bytes zero
   always_comb begin
      pkt    = '0;
      pkt[0] = HDR_BASE & ~{5'b0, evt_btn};
      pkt[1] = axis_byte[0];
      pkt[2] = axis_byte[1];
   end

   mpk_pkt_seq #(.LEN(PKT_LEN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_valid (evt_valid),
      .pkt_i     (pkt),
      .busy      (busy),
      .wr_en     (wr_en),
      .wr_data   (wr_data)
   );

   mpk_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .count   (fifo_count),
      .empty   (fifo_empty)
   );

   p_hdr_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !busy) |=> ((wr_data & 8'hF8) == 8'h80));
endmodule

// File: tb/tb_mouse_pkt_enc.sv
`timescale 1ns/1ps
module tb_mouse_pkt_enc;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_valid = 1'b0;
   logic [9:0] evt_dx = '0;
   logic [9:0] evt_dy = '0;
   logic [2:0] evt_btn = '0;
   logic       busy;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [8:0] fifo_count;
   logic       fifo_empty;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   mouse_pkt_enc dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_dx(evt_dx),
      .evt_dy(evt_dy), .evt_btn(evt_btn), .busy(busy), .rd_en(rd_en),
      .rd_data(rd_data), .fifo_count(fifo_count), .fifo_empty(fifo_empty)
   );

   localparam int NV = 8;
   localparam int VDX [NV] = '{0, 5, 300, -512, 127, -128, 511, -1};
   localparam int VDY [NV] = '{0, -3, -300, -512, -127, 128, 1, 0};
   localparam int VBT [NV] = '{0, 4, 7, 1, 2, 3, 5, 6};

   function automatic logic [7:0] clampb(int v);
      if (v > 127)  return 8'h7F;
      if (v < -127) return 8'h81;
      return 8'(v);
   endfunction

   function automatic logic [7:0] exp_byte(int dx, int dy, int bt, int k);
      case (k)
         0: return 8'h87 & ~8'(bt);
         1: return clampb(dx);
         2: return clampb(-dy);
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic send(int dx, int dy, int bt);
      evt_dx = 10'(dx); evt_dy = 10'(dy); evt_btn = 3'(bt);
      evt_valid = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic pop(output logic [7:0] b);
      b = rd_data;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] b;
      int n;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 busy", busy, 0);
      chk("R10 count", fifo_count, 0);
      chk("R10 empty", fifo_empty, 1);
      chk("R10 rd_data", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R1 R2 R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         send(VDX[v], VDY[v], VBT[v]);
         wait_idle();
         chk("R5 count", fifo_count, 5);
         for (int k = 0; k < 5; k++) begin
            pop(b);
            case (k)
               0: chk("R1 marker", b, exp_byte(VDX[v], VDY[v], VBT[v], k));
               1: chk("R2 x", b, exp_byte(VDX[v], VDY[v], VBT[v], k));
               2: chk("R3 y", b, exp_byte(VDX[v], VDY[v], VBT[v], k));
               default: chk("R4 zero", b, exp_byte(VDX[v], VDY[v], VBT[v], k));
            endcase
         end
         chk("R5 drained", fifo_empty, 1);
      end

      // R6 busy window length and one byte per cycle
      evt_dx = 10'd9; evt_dy = 10'd2; evt_btn = 3'd0; evt_valid = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0;
      n = 0;
      while (busy && n < 20) begin
         n++;
         chk("R6 rate", fifo_count, n - 1);
         @(negedge clk);
      end
      chk("R6 busy cycles", n, 5);
      chk("R6 bytes", fifo_count, 5);
      for (int k = 0; k < 5; k++) pop(b);

      // R7 sample during busy ignored
      send(10, 20, 1);
      evt_dx = 10'd50; evt_dy = 10'd60; evt_btn = 3'd7; evt_valid = 1'b1;
      @(negedge clk); @(negedge clk);
      evt_valid = 1'b0;
      wait_idle();
      repeat (2) @(negedge clk);
      chk("R7 count", fifo_count, 5);
      for (int k = 0; k < 5; k++) begin
         pop(b);
         chk("R7 content", b, exp_byte(10, 20, 1, k));
      end

      // R9 pop on empty
      chk("R9 empty data", rd_data, 0);
      pop(b);
      pop(b);
      chk("R9 count", fifo_count, 0);
      chk("R9 empty flag", fifo_empty, 1);
      chk("R9 data after", rd_data, 0);

      // R8 fill to overflow mid-packet
      for (int p = 0; p < 52; p++) begin
         send(p, -p, p % 8);
         wait_idle();
      end
      chk("R8 full count", fifo_count, 256);
      for (int j = 0; j < 256; j++) begin
         pop(b);
         chk("R8 order", b, exp_byte(j / 5, -(j / 5), (j / 5) % 8, j % 5));
      end
      chk("R8 drained", fifo_empty, 1);

      // R5 packets after wrap remain ordered
      send(-5, 7, 2);
      wait_idle();
      for (int k = 0; k < 5; k++) begin
         pop(b);
         chk("R5 wrap", b, exp_byte(-5, 7, 2, k));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule